// File: doc/BRIEF.md
# Cyclic Block Serial Master

This block drives the clocking side of a synchronous serial link that moves fixed blocks of eight bytes in both directions at once. A reloadable divider counts the system clock and produces one tick every `div_m1 + 1` clocks. Four ticks make one period of the shift clock. During each period the master drives one bit out on `sdo` and samples one bit in from `sdi`. Consecutive bytes of a block are separated by a configurable number of idle shift-clock periods.

Blocks repeat on a fixed cycle measured in system clocks. A free-running cycle counter marks the slot where a block may begin. A block begins there only if transfers are enabled and the link has been quiet for at least `hold_min` clocks since the previous block ended. That quiet time lets the far end resynchronise on the start of the next block. The 64-bit transmit word is sampled once, when the block begins. The 64-bit receive word is presented together with a single-cycle strobe when the block ends.

The data edges have no ready signal, because the link is strictly timed. `tx_block` is sampled without any handshake at the start of a block. `rx_valid` is a one-cycle pulse that cannot be held off, so a consumer must take `rx_block` in that cycle or copy it before the next block ends. `rx_block` holds its value until the next block ends.

Top module: `bsm_block_master`

## Requirements
- R1: One shift-clock period lasts 4*(div_m1+1) system clocks. Within each bit, `sclk` stays low for the first two ticks and high for the last two.
- R2: `sclk` is high whenever no block is in progress.
- R3: Bits go out least significant first. Bit i of byte b is `tx_block[8*b+i]`, and byte 0 goes first. `sdo` changes only on a falling edge of `sclk` and holds its value while `sclk` is low. Changes to `tx_block` after a block has begun do not affect that block.
- R4: `sdi` is sampled on each rising edge of `sclk`. The k-th bit received in a block lands in `rx_block[k]`.
- R5: Between consecutive bytes of a block, `sclk` stays high for `byte_gap` shift-clock periods. No gap follows the last byte. When `byte_gap` is 0, the bytes run back to back.
- R6: A block can begin only when the cycle counter reads 0. The counter starts at 0 after reset, counts system clocks and wraps after `blk_period` counts.
- R7: A block begins only if at least `hold_min` clocks have passed since the previous block ended. Otherwise that slot is skipped and the block waits for the next wrap.
- R8: `rx_valid` is high for exactly one cycle, 32*(8+byte_gap)-4*byte_gap ticks after the block began, that is (32*(8+byte_gap)-4*byte_gap)*(div_m1+1) clocks. In that same cycle `rx_block` carries the received data.
- R9: When `en` is low at a slot, no block begins. Dropping `en` in the middle of a block lets that block run to completion.
- R10: During reset, `sclk` = 1, `sdo` = 1, `rx_valid` = 0 and `rx_block` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Allows new blocks to begin |
| div_m1 | input | DIV_W | Divider reload value (division ratio minus one) |
| byte_gap | input | GAP_W | Idle shift-clock periods between bytes |
| blk_period | input | CYC_W | Length of the block cycle in system clocks |
| hold_min | input | CYC_W | Minimum quiet clocks between blocks |
| tx_block | input | 64 | Transmit block, sampled when a block begins |
| sdi | input | 1 | Serial data from the far end |
| sclk | output | 1 | Shift clock, idles high |
| sdo | output | 1 | Serial data to the far end |
| rx_block | output | 64 | Last block received |
| rx_valid | output | 1 | One-cycle strobe at the end of a block |

## Verification
A behavioural model in the bench computes the expected values of `sclk`, `sdo` and `rx_valid` on every clock. A design whose divider reloads one count late would drift away from that model within a few ticks. The bench changes `tx_block` while a block is in flight, so a design that feeds the shifter straight from the port would send mixed data to the far-end model in the bench. It also lowers `en` while a bit is mid-transfer, so a design that aborts the block would never pulse `rx_valid`. Finally, it chooses a block period that leaves less quiet time than `hold_min`, so a design that ignores the hold-off would start blocks every 300 clocks instead of every 600.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  localparam int BLK_BYTES = 8;
  localparam int BYTE_BITS = 8;
  localparam int BLK_BITS  = BLK_BYTES * BYTE_BITS;

  // quarter of one bit period, named by what the shift clock does next
  typedef enum logic [1:0] {
    PH_LEAD = 2'd0,
    PH_LOW1 = 2'd1,
    PH_LOW2 = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;
endpackage

// File: rtl/bsm_baud_div.sv
module bsm_baud_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] reload,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  // held at the reload value while idle, so every block starts phase-aligned
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run)           cnt_q <= reload;
    else if (cnt_q == '0)    cnt_q <= reload;
    else                     cnt_q <= cnt_q - DIV_W'(1);
  end

  assign tick = run && (cnt_q == '0);
endmodule

// File: rtl/bsm_blk_timer.sv
module bsm_blk_timer #(
  parameter int CYC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CYC_W-1:0] period,
  input  logic [CYC_W-1:0] hold_min,
  input  logic             busy,
  input  logic             done,
  output logic             start,
  output logic             wrap
);
  logic [CYC_W-1:0] cnt_q;
  logic [CYC_W-1:0] idle_q;
  logic [CYC_W:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt_q} + (CYC_W+1)'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (cnt_nxt >= {1'b0, period}) cnt_q <= '0;
    else                               cnt_q <= cnt_nxt[CYC_W-1:0];
  end

  // quiet-time counter, saturating, starts full so the first block may go
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        idle_q <= '1;
    else if (done)                     idle_q <= '0;
    else if (!busy && idle_q != '1)    idle_q <= idle_q + CYC_W'(1);
  end

  assign wrap  = (cnt_q == '0);
  assign start = wrap && en && !busy && (idle_q >= hold_min);
endmodule

// File: rtl/bsm_shift_engine.sv
module bsm_shift_engine
  import bsm_pkg::*;
#(
  parameter int GAP_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                tick,
  input  logic [GAP_W-1:0]    gap_len,
  input  logic [BLK_BITS-1:0] tx_block,
  input  logic                sdi,
  output logic                busy,
  output logic                sclk,
  output logic                sdo,
  output logic                done,
  output logic [BLK_BITS-1:0] rx_shift
);
  localparam int GC_W   = GAP_W + 2;
  localparam int BIT_W  = $clog2(BYTE_BITS);
  localparam int BYTE_W = $clog2(BLK_BYTES);

  phase_e              ph_q;
  logic [BIT_W-1:0]    bit_q;
  logic [BYTE_W-1:0]   byte_q;
  logic                in_gap_q;
  logic [GC_W-1:0]     gap_cnt_q;
  logic [BLK_BITS-1:0] tx_sh_q;
  logic                last_bit, last_byte;

  assign last_bit  = (bit_q == BIT_W'(BYTE_BITS-1));
  assign last_byte = (byte_q == BYTE_W'(BLK_BYTES-1));
  assign done      = busy && tick && !in_gap_q && (ph_q == PH_HIGH) && last_bit && last_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      sclk      <= 1'b1;
      sdo       <= 1'b1;
      ph_q      <= PH_LEAD;
      bit_q     <= '0;
      byte_q    <= '0;
      in_gap_q  <= 1'b0;
      gap_cnt_q <= '0;
      tx_sh_q   <= '0;
      rx_shift  <= '0;
    end else if (start) begin
      busy      <= 1'b1;
      sclk      <= 1'b1;
      ph_q      <= PH_LEAD;
      bit_q     <= '0;
      byte_q    <= '0;
      in_gap_q  <= 1'b0;
      gap_cnt_q <= '0;
      tx_sh_q   <= tx_block;
    end else if (busy && tick) begin
      if (in_gap_q) begin
        if (gap_cnt_q == '0) in_gap_q  <= 1'b0;
        else                 gap_cnt_q <= gap_cnt_q - GC_W'(1);
      end else begin
        unique case (ph_q)
          PH_LEAD: begin
            sclk    <= 1'b0;
            sdo     <= tx_sh_q[0];
            tx_sh_q <= tx_sh_q >> 1;
            ph_q    <= PH_LOW1;
          end
          PH_LOW1: ph_q <= PH_LOW2;
          PH_LOW2: begin
            sclk     <= 1'b1;
            rx_shift <= {sdi, rx_shift[BLK_BITS-1:1]};
            ph_q     <= PH_HIGH;
          end
          PH_HIGH: begin
            ph_q <= PH_LEAD;
            if (last_bit) begin
              bit_q <= '0;
              if (last_byte) begin
                busy <= 1'b0;
              end else begin
                byte_q <= byte_q + BYTE_W'(1);
                if (gap_len != '0) begin
                  in_gap_q  <= 1'b1;
                  gap_cnt_q <= {gap_len, 2'b00} - GC_W'(1);
                end
              end
            end else begin
              bit_q <= bit_q + BIT_W'(1);
            end
          end
          default: ph_q <= PH_LEAD;
        endcase
      end
    end
  end

  // R5: the clock rests high through every inter-byte gap
  a_r5_gap_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
    in_gap_q |-> sclk)
    else $error("a_r5_gap_clock_high");

  // R3: data is frozen while the shift clock stays low
  a_r3_sdo_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk && $past(!sclk)) |-> $stable(sdo))
    else $error("a_r3_sdo_hold_low");

  // R8: the last tick of a block releases the engine
  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy)
    else $error("a_r8_done_ends_busy");
endmodule

// File: rtl/bsm_block_master.sv
module bsm_block_master
  import bsm_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int GAP_W = 4,
  parameter int CYC_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [DIV_W-1:0]    div_m1,
  input  logic [GAP_W-1:0]    byte_gap,
  input  logic [CYC_W-1:0]    blk_period,
  input  logic [CYC_W-1:0]    hold_min,
  input  logic [BLK_BITS-1:0] tx_block,
  input  logic                sdi,
  output logic                sclk,
  output logic                sdo,
  output logic [BLK_BITS-1:0] rx_block,
  output logic                rx_valid
);
  logic                tick, start, wrap, busy, done;
  logic [BLK_BITS-1:0] rx_shift;

  bsm_baud_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .reload(div_m1), .tick(tick)
  );

  bsm_blk_timer #(.CYC_W(CYC_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .en(en), .period(blk_period), .hold_min(hold_min),
    .busy(busy), .done(done), .start(start), .wrap(wrap)
  );

  bsm_shift_engine #(.GAP_W(GAP_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick), .gap_len(byte_gap),
    .tx_block(tx_block), .sdi(sdi), .busy(busy), .sclk(sclk), .sdo(sdo),
    .done(done), .rx_shift(rx_shift)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_block <= '0;
    end else begin
      rx_valid <= done;
      if (done) rx_block <= rx_shift;
    end
  end

  // R8: strobe never lasts two cycles
  a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid)
    else $error("a_r8_valid_single");

  // R2: clock at rest outside a block
  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk)
    else $error("a_r2_idle_high");

  // R6: a block only ever begins in the wrap slot
  a_r6_start_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wrap))
    else $error("a_r6_start_at_wrap");
endmodule

// File: tb/tb_bsm_block_master.sv
module tb_bsm_block_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 8, GAP_W = 4, CYC_W = 16;
  localparam int IDLE_MAX = 65535;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, sdi = 1'b0;
  logic [DIV_W-1:0] div_m1;
  logic [GAP_W-1:0] byte_gap;
  logic [CYC_W-1:0] blk_period, hold_min;
  logic [63:0] tx_block;
  wire sclk, sdo, rx_valid;
  wire [63:0] rx_block;

  bsm_block_master #(.DIV_W(DIV_W), .GAP_W(GAP_W), .CYC_W(CYC_W)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .div_m1(div_m1), .byte_gap(byte_gap),
    .blk_period(blk_period), .hold_min(hold_min), .tx_block(tx_block), .sdi(sdi),
    .sclk(sclk), .sdo(sdo), .rx_block(rx_block), .rx_valid(rx_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, n_done = 0;
  int done_at[$];

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h cycle=%0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference: state visible in the current cycle
  int m_cnt = 0, m_el = 0, m_idle = IDLE_MAX;
  bit m_busy = 0, m_done = 0;
  logic [63:0] m_tx = '0;

  function automatic int blk_len();
    return (7 * 4 * (8 + int'(byte_gap)) + 32) * (int'(div_m1) + 1);
  endfunction

  always @(posedge clk) begin
    bit st;
    cyc++;
    if (!rst_n) begin
      m_cnt = 0; m_busy = 0; m_el = 0; m_idle = IDLE_MAX; m_done = 0;
    end else begin
      st = (m_cnt == 0) && en && !m_busy && (m_idle >= int'(hold_min));
      if (st) begin
        m_busy = 1; m_el = 0; m_tx = tx_block; m_done = 0;
      end else if (m_busy) begin
        if (m_el + 1 == blk_len()) begin
          m_busy = 0; m_done = 1; m_idle = 0;
        end else begin
          m_el++; m_done = 0;
        end
      end else begin
        m_done = 0;
        if (m_idle < IDLE_MAX) m_idle++;
      end
      m_cnt = (m_cnt + 1 >= int'(blk_period)) ? 0 : m_cnt + 1;
    end
  end

  // far-end model: drives on falling edges, captures on rising edges
  logic [63:0] sl_data, sl_cap = '0;
  int sl_idx = 0;
  always @(negedge sclk) if (rst_n) sdi <= sl_data[sl_idx];
  always @(posedge sclk) if (rst_n) begin
    sl_cap[sl_idx] <= sdo;
    sl_idx <= (sl_idx + 1) % 64;
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    int m, per, b, r, qq, j;
    logic exp_sclk;
    if (rst_n) begin
      exp_sclk = 1'b1;
      if (m_busy) begin
        m   = m_el / (int'(div_m1) + 1);
        per = 4 * (8 + int'(byte_gap));
        b   = m / per;
        r   = m % per;
        if (r < 32) begin
          qq = r % 4; j = r / 4;
          exp_sclk = !(qq == 1 || qq == 2);
          if (qq != 0) chk("R3 sdo bit", {63'd0, sdo}, {63'd0, m_tx[8*b+j]});
          chk("R1 sclk in bit", {63'd0, sclk}, {63'd0, exp_sclk});
        end else begin
          chk("R5 sclk in byte gap", {63'd0, sclk}, 64'd1);
        end
      end else begin
        chk("R2 sclk idle", {63'd0, sclk}, 64'd1);
      end
      chk("R8 rx_valid timing", {63'd0, rx_valid}, {63'd0, m_done});
      if (rx_valid) begin
        chk("R4 rx_block", rx_block, sl_data);
        chk("R3 far end got tx", sl_cap, m_tx);
        n_done++;
        done_at.push_back(cyc);
      end
    end
  end

  task automatic wait_done(int n);
    while (n_done < n) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    div_m1 = 8'd1; byte_gap = 4'd1; blk_period = 16'd700; hold_min = 16'd50;
    tx_block = 64'h0123_4567_89AB_CDEF; sl_data = 64'hF0E1_D2C3_B4A5_9687;
    repeat (3) @(negedge clk);
    chk("R10 reset sclk", {63'd0, sclk}, 64'd1);
    chk("R10 reset sdo", {63'd0, sdo}, 64'd1);
    chk("R10 reset rx_valid", {63'd0, rx_valid}, 64'd0);
    chk("R10 reset rx_block", rx_block, 64'd0);
    rst_n = 1'b1; en = 1'b1;
    // change transmit word mid-block: block must keep the sampled one
    repeat (100) @(negedge clk);
    tx_block = 64'hDEAD_BEEF_CAFE_F00D;
    wait_done(1);
    sl_data = 64'h5A3C_0FF0_C3A5_1E87;
    wait_done(2);
    chk("R6 block spacing", 64'(done_at[1] - done_at[0]), 64'd700);
    // drop enable mid-bit of block three
    while (!(n_done == 2 && sclk == 1'b0)) @(negedge clk);
    en = 1'b0;
    repeat (2000) @(negedge clk);
    chk("R9 block finishes, no new block", 64'(n_done), 64'd3);
    // back-to-back bytes, hold-off longer than idle slot
    div_m1 = 8'd0; byte_gap = 4'd0; blk_period = 16'd300; hold_min = 16'd100;
    tx_block = 64'h8000_0000_0000_0001;
    en = 1'b1;
    wait_done(5);
    chk("R7 skipped slot", 64'(done_at[4] - done_at[3]), 64'd600);
    hold_min = 16'd40;
    wait_done(7);
    chk("R7 hold met every slot", 64'(done_at[6] - done_at[5]), 64'd300);
    en = 1'b0;
    repeat (10) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule